// File: doc/BRIEF.md
# CAN Overload Condition Detector

This block sits beside a CAN protocol engine and decides, bit by bit, whether the node must begin an overload frame. For every sampled bus bit the engine presents the bit value with a one-cycle strobe, plus a code telling which frame field the bit belongs to, the bit's zero-based index within that field, and whether the node is currently a receiver. The detector checks each strobed bit against the small set of bus positions where a dominant level means "overload", and answers with a single-cycle request that the engine uses to start driving the overload flag at the next bit time.

Only four field codes matter (end-of-frame, intermission, error delimiter, overload delimiter); every other field code is inert. A dominant level at the third intermission bit is left to the engine as a start of frame. The bit stream cannot be stalled, because the bus sets the pace: the input side has a valid strobe but no ready, and the request output carries no back-pressure. The engine must take the request in the cycle it is high. Strobes are expected to arrive at least two clock cycles apart, which holds for any practical bit time.

Top module: `can_ovld_detect`

## Requirements
- R1: A synchronous active-high reset forces `ovld_req` low in the cycle after any clock edge where `rst` is high, including when a triggering bit is strobed at that same edge.
- R2: A dominant bit (`bit_val` = 0) strobed with field code 2 (intermission) at index 0 or 1 raises `ovld_req`, whatever the value of `node_rx`.
- R3: A dominant bit strobed with field code 2 at index 2 or higher raises no request.
- R4: A dominant bit strobed with field code 1 (end-of-frame) at index 6 while `node_rx` = 1 raises `ovld_req`.
- R5: A dominant bit strobed with field code 1 at index 6 while `node_rx` = 0 raises no request. The same holds for end-of-frame bits at any other index.
- R6: A dominant bit strobed with field code 3 (error delimiter) at index 7 raises `ovld_req`. Other indices in that field raise no request.
- R7: A dominant bit strobed with field code 4 (overload delimiter) at index 7 raises `ovld_req`. Other indices in that field raise no request.
- R8: A recessive bit (`bit_val` = 1) never raises a request. Field code 0 and codes 5 to 7 never raise a request.
- R9: Without `bit_vld` the inputs have no effect, and `ovld_req` stays low.
- R10: The request is registered. It is high for exactly the one clock cycle after the strobe edge and is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | One-cycle strobe marking a sampled bus bit |
| bit_val | input | 1 | Sampled bus level, 0 dominant and 1 recessive |
| field_code | input | 3 | Field of the bit: 0 other, 1 end-of-frame, 2 intermission, 3 error delimiter, 4 overload delimiter |
| bit_idx | input | IDX_W (4) | Zero-based bit index within the field |
| node_rx | input | 1 | 1 while the node receives the current frame, 0 while it transmits |
| ovld_req | output | 1 | One-cycle overload-start request |

## Verification
The bench probes the edges of every trigger window. It drives intermission index 2, where an off-by-one design would start an overload on a legal start of frame. It drives end-of-frame index 5, where a wrong index would fire one bit early. It also drives the last end-of-frame bit while transmitting, where a design that ignores the direction flag would wrongly treat its own frame as overloaded. Recessive bits at trigger positions and matching inputs held without a strobe catch a detector that forgets the bus level or the strobe. A trigger strobed during reset, and the cycle after each request, catch a stuck or stretched pulse.

// File: rtl/can_ovld_pkg.sv
package can_ovld_pkg;
  typedef enum logic [2:0] {
    FLD_OTHER  = 3'd0,
    FLD_EOF    = 3'd1,
    FLD_IFS    = 3'd2,
    FLD_ERRDLM = 3'd3,
    FLD_OVLDLM = 3'd4
  } fld_e;

  localparam logic BUS_DOM = 1'b0;
endpackage

// File: rtl/can_ovld_pos_decode.sv
module can_ovld_pos_decode
  import can_ovld_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int IFS_EARLY = 2,
  parameter int EOF_LAST  = 6,
  parameter int DLM_LAST  = 7
) (
  input  logic [2:0]       field_code,
  input  logic [IDX_W-1:0] bit_idx,
  output logic             at_ifs_early,
  output logic             at_eof_last,
  output logic             at_dlm_last
);
  localparam logic [IDX_W-1:0] EOF_IDX = IDX_W'(EOF_LAST);
  localparam logic [IDX_W-1:0] DLM_IDX = IDX_W'(DLM_LAST);

  logic [IFS_EARLY-1:0] ifs_hit;

  // one comparator per early intermission position
  for (genvar g = 0; g < IFS_EARLY; g++) begin : g_ifs
    assign ifs_hit[g] = (bit_idx == IDX_W'(g));
  end

  always_comb begin
    at_ifs_early = (field_code == FLD_IFS) && (|ifs_hit);
    at_eof_last  = (field_code == FLD_EOF) && (bit_idx == EOF_IDX);
    at_dlm_last  = ((field_code == FLD_ERRDLM) || (field_code == FLD_OVLDLM))
                   && (bit_idx == DLM_IDX);
  end
endmodule

// File: rtl/can_ovld_qualify.sv
module can_ovld_qualify
  import can_ovld_pkg::*;
(
  input  logic bit_vld,
  input  logic bit_val,
  input  logic node_rx,
  input  logic at_ifs_early,
  input  logic at_eof_last,
  input  logic at_dlm_last,
  output logic cond_hit
);
  logic dom;
  logic pos_ok;

  always_comb begin
    dom      = (bit_val == BUS_DOM);
    // end-of-frame position counts only for a receiver
    pos_ok   = at_ifs_early || at_dlm_last || (at_eof_last && node_rx);
    cond_hit = bit_vld && dom && pos_ok;
  end
endmodule

// File: rtl/can_ovld_pulse.sv
module can_ovld_pulse (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_val,
  input  logic cond_hit,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= cond_hit;
  end

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !req);
  assert_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(bit_vld));
  assert_recessive_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    req |-> !$past(bit_val));
  assert_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (req && !bit_vld) |=> !req);
endmodule

// File: rtl/can_ovld_detect.sv
module can_ovld_detect
  import can_ovld_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int IFS_EARLY = 2,
  parameter int EOF_LAST  = 6,
  parameter int DLM_LAST  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic [2:0]       field_code,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             node_rx,
  output logic             ovld_req
);
  logic at_ifs_early, at_eof_last, at_dlm_last, cond_hit;

  can_ovld_pos_decode #(
    .IDX_W(IDX_W), .IFS_EARLY(IFS_EARLY), .EOF_LAST(EOF_LAST), .DLM_LAST(DLM_LAST)
  ) u_pos (
    .field_code(field_code), .bit_idx(bit_idx),
    .at_ifs_early(at_ifs_early), .at_eof_last(at_eof_last), .at_dlm_last(at_dlm_last)
  );

  can_ovld_qualify u_qual (
    .bit_vld(bit_vld), .bit_val(bit_val), .node_rx(node_rx),
    .at_ifs_early(at_ifs_early), .at_eof_last(at_eof_last), .at_dlm_last(at_dlm_last),
    .cond_hit(cond_hit)
  );

  can_ovld_pulse u_pulse (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
    .cond_hit(cond_hit), .req(ovld_req)
  );

  assert_sof_not_overload_R3: assert property (@(posedge clk) disable iff (rst)
    ovld_req |-> !($past(field_code) == FLD_IFS && $past(bit_idx) >= IDX_W'(IFS_EARLY)));
  assert_eof_tx_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ovld_req |-> !($past(field_code) == FLD_EOF && !$past(node_rx)));
  assert_inert_fields_R8: assert property (@(posedge clk) disable iff (rst)
    ovld_req |-> ($past(field_code) inside {FLD_EOF, FLD_IFS, FLD_ERRDLM, FLD_OVLDLM}));
endmodule

// File: tb/can_ovld_detect_test.sv
module can_ovld_detect_test;
  localparam int CLK_P = 10;
  localparam int NV = 17;
  // {field[9:7], idx[6:3], val[2], rx[1], expected[0]}
  localparam logic [9:0] VEC [0:NV-1] = '{
    {3'd2, 4'd0, 1'b0, 1'b1, 1'b1},  // R2
    {3'd2, 4'd1, 1'b0, 1'b0, 1'b1},  // R2
    {3'd2, 4'd2, 1'b0, 1'b1, 1'b0},  // R3
    {3'd2, 4'd3, 1'b0, 1'b0, 1'b0},  // R3
    {3'd1, 4'd6, 1'b0, 1'b1, 1'b1},  // R4
    {3'd1, 4'd6, 1'b0, 1'b0, 1'b0},  // R5
    {3'd1, 4'd5, 1'b0, 1'b1, 1'b0},  // R5
    {3'd3, 4'd7, 1'b0, 1'b0, 1'b1},  // R6
    {3'd3, 4'd6, 1'b0, 1'b1, 1'b0},  // R6
    {3'd4, 4'd7, 1'b0, 1'b1, 1'b1},  // R7
    {3'd4, 4'd0, 1'b0, 1'b0, 1'b0},  // R7
    {3'd2, 4'd0, 1'b1, 1'b1, 1'b0},  // R8
    {3'd1, 4'd6, 1'b1, 1'b1, 1'b0},  // R8
    {3'd4, 4'd7, 1'b1, 1'b0, 1'b0},  // R8
    {3'd0, 4'd7, 1'b0, 1'b1, 1'b0},  // R8
    {3'd5, 4'd0, 1'b0, 1'b1, 1'b0},  // R8
    {3'd3, 4'd7, 1'b0, 1'b1, 1'b1}   // R6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, bit_val = 1'b1, node_rx = 1'b0;
  logic [2:0] field_code = 3'd0;
  logic [3:0] bit_idx = 4'd0;
  logic ovld_req;
  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  can_ovld_detect uut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
    .field_code(field_code), .bit_idx(bit_idx), .node_rx(node_rx),
    .ovld_req(ovld_req)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ovld_req=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [9:0] v, input logic vld);
    field_code = v[9:7]; bit_idx = v[6:3]; bit_val = v[2]; node_rx = v[1];
    bit_vld = vld;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: ovld_req=%b expected finish", ovld_req);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ovld_req, 1'b0, "R1 reset state");
    // R1: trigger strobed while reset is high
    drive(VEC[0], 1'b1);
    @(negedge clk);
    check(ovld_req, 1'b0, "R1 trigger under reset");
    bit_vld = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
      check(ovld_req, VEC[i][0], $sformatf("vector %0d (R2..R8)", i));
      bit_vld = 1'b0;
      @(negedge clk);
      check(ovld_req, 1'b0, "R10 pulse ends");
      @(negedge clk);
    end

    // R9: matching inputs held without strobe
    drive(VEC[4], 1'b0);
    repeat (3) @(negedge clk);
    check(ovld_req, 1'b0, "R9 no strobe");

    // R1: reset right after a trigger strobe clears request
    drive(VEC[9], 1'b1);
    @(negedge clk);
    check(ovld_req, 1'b1, "R7 before reset");
    bit_vld = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(ovld_req, 1'b0, "R1 reset clears");
    rst = 1'b0;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule